// File: doc/BRIEF.md
# Three-Stage Accumulator Instruction Pipeline

This block is a small in-order processor core built as a three-stage pipeline for a single-accumulator instruction set. The stages are fetch, decode and execute. In steady state each stage holds a different instruction, so up to three instructions are in flight at once. Instructions come from a synchronous instruction memory port. Operands are read from, and results written to, a data memory that has separate read and write ports.

The program counter is loaded from `start_addr` while reset is held. It then steps through memory one word per cycle. A jump that is taken in execute discards both younger instructions and restarts fetch at the jump's address field. A HALT that reaches execute stops fetch and freezes the whole pipe until the next reset.

Two counters are exposed on output ports. One counts retired instructions and the other counts discarded slots. Both memory ports have a fixed latency of one cycle and take no back-pressure, so they carry no valid/ready handshake: a read issued in one cycle returns its data in the next.

Top module: `acc_pipe3`

## Requirements
- R1: While `rst_n` is low, `imem_addr` equals `start_addr`, and `acc`, both flags, `halted`, `retire_cnt` and `flush_cnt` are all zero.
- R2: Each cycle that is neither redirected nor halted, the fetch address advances by one, wrapping modulo 2^ADDR_W.
- R3: After reset is released, the first instruction retires at the end of the third cycle. A program of N executed instructions (HALT included) with J taken jumps raises `halted` after exactly N+2+2J cycles.
- R4: An instruction word holds an opcode in bits [ADDR_W+2:ADDR_W] and an address in bits [ADDR_W-1:0]. The opcodes are 0 NOP, 1 LOAD, 2 ADD, 3 STORE, 4 JMP, 5 JZ and 7 HALT; code 6 behaves as NOP. LOAD copies memory to `acc`, sets the zero flag and clears carry. ADD adds memory to `acc` and sets zero and carry (the carry-out). STORE writes `acc` to memory.
- R5: When a jump is taken in execute, `imem_addr` in the next cycle equals the jump's address field, and `flush_cnt` rises by 2, the two younger slots that were discarded.
- R6: JZ is taken only when the zero flag is set. When it is not taken, the sequence continues without any flush.
- R7: Discarded slots change neither `acc`, nor the flags, nor data memory.
- R8: A LOAD or ADD that directly follows a STORE to the same address sees the stored value.
- R9: Once HALT executes, `imem_en`, `dmem_ren` and `dmem_we` stay low, and `acc`, the flags and both counters hold their values until reset.
- R10: `retire_cnt` counts every executed instruction, HALT included, and never counts a discarded slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | ADDR_W | Program counter value loaded during reset |
| imem_en | output | 1 | Instruction read strobe |
| imem_addr | output | ADDR_W | Instruction read address |
| imem_rdata | input | ADDR_W+3 | Instruction word, one cycle after the address |
| dmem_ren | output | 1 | Data read strobe, issued from decode |
| dmem_raddr | output | ADDR_W | Data read address |
| dmem_rdata | input | DATA_W | Data read result, one cycle after the address |
| dmem_we | output | 1 | Data write strobe from execute |
| dmem_waddr | output | ADDR_W | Data write address |
| dmem_wdata | output | DATA_W | Data write value |
| acc | output | DATA_W | Accumulator |
| zero_flag | output | 1 | Zero result of the last LOAD or ADD |
| carry_flag | output | 1 | Carry-out of the last ADD |
| halted | output | 1 | HALT has executed |
| retire_cnt | output | CNT_W | Executed instruction count |
| flush_cnt | output | CNT_W | Discarded slot count |

## Verification
Straight-line code that wraps across the top of the address space separates the stepping of the fetch address from its overlap timing. A STORE followed at once by a LOAD of the same word shows whether the memory read-after-write case is handled. Chained unconditional and conditional jumps, each with stores and adds placed behind it, show whether the flush really suppresses the discarded work and charges exactly two cycles. Random forward-jumping programs over a small data region mix every opcode, zero and carry conditions, and back-to-back memory reuse. They are compared with an instruction-by-instruction model on the final state, both counters and the cycle at which the core halts.

// File: rtl/acc_pipe3_pkg.sv
package acc_pipe3_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_STORE = 3'd3,
    OP_JMP   = 3'd4,
    OP_JZ    = 3'd5,
    OP_RSV   = 3'd6,
    OP_HALT  = 3'd7
  } op_e;

  function automatic logic op_reads_mem(op_e op);
    return (op == OP_LOAD) || (op == OP_ADD);
  endfunction
endpackage

// File: rtl/acc_pipe3_fetch.sv
module acc_pipe3_fetch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              freeze,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] target,
  output logic              imem_en,
  output logic [ADDR_W-1:0] imem_addr,
  output logic              f_valid
);
  logic [ADDR_W-1:0] pc_q;

  assign imem_en   = !freeze;
  assign imem_addr = pc_q;

  // The memory output register acts as the fetch register; f_valid tags it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= start_addr;
      f_valid <= 1'b0;
    end else if (freeze) begin
      pc_q    <= pc_q;
      f_valid <= f_valid;
    end else if (redirect) begin
      pc_q    <= target;
      f_valid <= 1'b0;
    end else begin
      pc_q    <= pc_q + 1'b1;
      f_valid <= 1'b1;
    end
  end

  // R2: sequential stepping
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !redirect) |=> imem_addr == ADDR_W'($past(imem_addr) + 1'b1));

  // R5: redirect lands on the target and kills the in-flight fetch
  a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (imem_addr == $past(target)) && !f_valid);

  // R9: no fetch movement while frozen
  a_r9_fetch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(imem_addr) && $stable(f_valid));
endmodule

// File: rtl/acc_pipe3_decode.sv
module acc_pipe3_decode
  import acc_pipe3_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   f_valid,
  input  logic [OP_W+ADDR_W-1:0] instr,
  input  logic                   flush,
  input  logic                   freeze,
  output logic                   dmem_ren,
  output logic [ADDR_W-1:0]      dmem_raddr,
  output logic                   e_valid,
  output op_e                    e_op,
  output logic [ADDR_W-1:0]      e_addr,
  output logic                   e_fwd
);
  op_e               d_op;
  logic [ADDR_W-1:0] d_addr;
  logic              store_hit;

  assign d_op   = op_e'(instr[OP_W+ADDR_W-1:ADDR_W]);
  assign d_addr = instr[ADDR_W-1:0];

  // Operand read is issued here so data is ready in execute.
  assign dmem_ren   = f_valid && op_reads_mem(d_op) && !freeze && !flush;
  assign dmem_raddr = d_addr;

  // The store now in execute writes at this edge; the read sees old data.
  assign store_hit = e_valid && (e_op == OP_STORE) && (e_addr == d_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      e_op    <= OP_NOP;
      e_addr  <= '0;
      e_fwd   <= 1'b0;
    end else if (freeze) begin
      e_valid <= e_valid;
    end else begin
      e_valid <= f_valid && !flush;
      e_op    <= d_op;
      e_addr  <= d_addr;
      e_fwd   <= store_hit;
    end
  end

  // R7: flush empties the execute register
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !e_valid);

  // R9: execute register frozen after halt
  a_r9_decode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(e_valid) && $stable(e_op));
endmodule

// File: rtl/acc_pipe3_exec.sv
module acc_pipe3_exec
  import acc_pipe3_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_valid,
  input  op_e               e_op,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic              e_fwd,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              dmem_we,
  output logic [ADDR_W-1:0] dmem_waddr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              redirect,
  output logic [ADDR_W-1:0] target,
  output logic              halt_now,
  output logic              halted,
  output logic              retire,
  output logic [DATA_W-1:0] acc,
  output logic              zero_flag,
  output logic              carry_flag
);
  logic              live;
  logic [DATA_W-1:0] operand;
  logic [DATA_W:0]   sum;

  assign live    = e_valid && !halted;
  assign operand = e_fwd ? acc : dmem_rdata;
  assign sum     = {1'b0, acc} + {1'b0, operand};

  assign dmem_waddr = e_addr;
  assign dmem_wdata = acc;
  assign target     = e_addr;
  assign retire     = live;

  always_comb begin
    dmem_we  = 1'b0;
    redirect = 1'b0;
    halt_now = 1'b0;
    if (live) begin
      case (e_op)
        OP_STORE: dmem_we  = 1'b1;
        OP_JMP:   redirect = 1'b1;
        OP_JZ:    redirect = zero_flag;
        OP_HALT:  halt_now = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
      halted     <= 1'b0;
    end else if (live) begin
      case (e_op)
        OP_LOAD: begin
          acc        <= operand;
          zero_flag  <= (operand == '0);
          carry_flag <= 1'b0;
        end
        OP_ADD: begin
          acc        <= sum[DATA_W-1:0];
          zero_flag  <= (sum[DATA_W-1:0] == '0);
          carry_flag <= sum[DATA_W];
        end
        default: ;
      endcase
      if (halt_now) halted <= 1'b1;
    end
  end

  // R9: architectural state frozen after halt
  a_r9_exec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(acc) && $stable(zero_flag) && $stable(carry_flag) && halted);

  // R7: an empty execute slot has no side effect
  a_r7_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !e_valid |=> $stable(acc) && $stable(zero_flag) && $stable(carry_flag));

  // R6: a JZ with the zero flag clear never redirects
  a_r6_jz_untaken: assert property (@(posedge clk) disable iff (!rst_n)
    (e_op == OP_JZ && !zero_flag) |-> !redirect);
endmodule

// File: rtl/acc_pipe3_count.sv
module acc_pipe3_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic [1:0]       flush_n,
  output logic [CNT_W-1:0] retire_cnt,
  output logic [CNT_W-1:0] flush_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire_cnt <= '0;
      flush_cnt  <= '0;
    end else begin
      retire_cnt <= retire_cnt + CNT_W'(retire);
      flush_cnt  <= flush_cnt + CNT_W'(flush_n);
    end
  end

  // R10: at most one retirement per cycle
  a_r10_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (CNT_W'(retire_cnt - $past(retire_cnt)) <= CNT_W'(1)));

  // R5: a flush discards at most two slots
  a_r5_flush_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (CNT_W'(flush_cnt - $past(flush_cnt)) <= CNT_W'(2)));
endmodule

// File: rtl/acc_pipe3.sv
module acc_pipe3
  import acc_pipe3_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      start_addr,
  output logic                   imem_en,
  output logic [ADDR_W-1:0]      imem_addr,
  input  logic [OP_W+ADDR_W-1:0] imem_rdata,
  output logic                   dmem_ren,
  output logic [ADDR_W-1:0]      dmem_raddr,
  input  logic [DATA_W-1:0]      dmem_rdata,
  output logic                   dmem_we,
  output logic [ADDR_W-1:0]      dmem_waddr,
  output logic [DATA_W-1:0]      dmem_wdata,
  output logic [DATA_W-1:0]      acc,
  output logic                   zero_flag,
  output logic                   carry_flag,
  output logic                   halted,
  output logic [CNT_W-1:0]       retire_cnt,
  output logic [CNT_W-1:0]       flush_cnt
);
  logic              f_valid;
  logic              e_valid;
  op_e               e_op;
  logic [ADDR_W-1:0] e_addr;
  logic              e_fwd;
  logic              redirect;
  logic [ADDR_W-1:0] target;
  logic              halt_now;
  logic              freeze;
  logic              retire;
  logic [1:0]        flush_n;

  assign freeze = halted || halt_now;
  // Discarded: the slot in decode (if valid) plus the fetch issued this cycle.
  assign flush_n = redirect ? (2'(f_valid) + 2'd1) : 2'd0;

  acc_pipe3_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .freeze(freeze),
    .redirect(redirect), .target(target), .imem_en(imem_en),
    .imem_addr(imem_addr), .f_valid(f_valid)
  );

  acc_pipe3_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .instr(imem_rdata),
    .flush(redirect), .freeze(freeze), .dmem_ren(dmem_ren),
    .dmem_raddr(dmem_raddr), .e_valid(e_valid), .e_op(e_op),
    .e_addr(e_addr), .e_fwd(e_fwd)
  );

  acc_pipe3_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .e_valid(e_valid), .e_op(e_op), .e_addr(e_addr),
    .e_fwd(e_fwd), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
    .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata), .redirect(redirect),
    .target(target), .halt_now(halt_now), .halted(halted), .retire(retire),
    .acc(acc), .zero_flag(zero_flag), .carry_flag(carry_flag)
  );

  acc_pipe3_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .retire(retire), .flush_n(flush_n),
    .retire_cnt(retire_cnt), .flush_cnt(flush_cnt)
  );

  // R9: a halted core touches no memory port and counts nothing
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_en && !dmem_ren && !dmem_we);

  a_r9_counts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(retire_cnt) && $stable(flush_cnt));
endmodule

// File: tb/acc_pipe3_tb.sv
module acc_pipe3_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = AW + 3;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          imem_en, dmem_ren, dmem_we, zero_flag, carry_flag, halted;
  logic [AW-1:0] imem_addr, dmem_raddr, dmem_waddr;
  logic [IW-1:0] iq = '0;
  logic [DW-1:0] dq = '0;
  logic [DW-1:0] dmem_wdata, acc;
  logic [CW-1:0] retire_cnt, flush_cnt;

  logic [IW-1:0] prog [256];
  logic [DW-1:0] dm   [256];
  logic [DW-1:0] rdm  [256];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int total = 0;
  logic [AW-1:0] tr_addr [64];
  int            tr_ret  [64];

  logic [DW-1:0] r_acc;
  logic          r_z, r_c;
  int            r_ret, r_jmp;

  always #4 clk = ~clk;

  acc_pipe3 u_dut (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .imem_en(imem_en),
    .imem_addr(imem_addr), .imem_rdata(iq), .dmem_ren(dmem_ren),
    .dmem_raddr(dmem_raddr), .dmem_rdata(dq), .dmem_we(dmem_we),
    .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata), .acc(acc),
    .zero_flag(zero_flag), .carry_flag(carry_flag), .halted(halted),
    .retire_cnt(retire_cnt), .flush_cnt(flush_cnt)
  );

  always @(posedge clk) begin
    if (imem_en) iq <= prog[imem_addr];
    if (dmem_ren) dq <= dm[dmem_raddr];
    if (dmem_we) dm[dmem_waddr] <= dmem_wdata;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(posedge clk) total <= total + 1;

  always @(negedge clk) begin
    if (rst_n && cyc < 64) begin
      tr_addr[cyc] = imem_addr;
      tr_ret[cyc]  = int'(retire_cnt);
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    wait (total > 150000);
    checks++;
    failures++;
    $display("FAIL R9 watchdog: actual=%0d expected=halt", total);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Instruction-level model of R4, R5, R6, R10.
  task automatic ref_run(input logic [AW-1:0] s);
    logic [AW-1:0] pc;
    logic [DW:0]   t;
    logic [2:0]    op;
    logic [AW-1:0] a;
    pc = s; r_acc = '0; r_z = 1'b0; r_c = 1'b0; r_ret = 0; r_jmp = 0;
    for (int k = 0; k < 2000; k++) begin
      op = prog[pc][IW-1:AW];
      a  = prog[pc][AW-1:0];
      r_ret++;
      pc = pc + 1'b1;
      if (op == 3'd7) break;
      case (op)
        3'd1: begin r_acc = rdm[a]; r_z = (r_acc == 0); r_c = 1'b0; end
        3'd2: begin
          t = {1'b0, r_acc} + {1'b0, rdm[a]};
          r_acc = t[DW-1:0]; r_z = (r_acc == 0); r_c = t[DW];
        end
        3'd3: rdm[a] = r_acc;
        3'd4: begin pc = a; r_jmp++; end
        3'd5: if (r_z) begin pc = a; r_jmp++; end
        default: ;
      endcase
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = {3'd7, 8'd0};
  endtask

  task automatic put(input logic [AW-1:0] s, input int off, input logic [2:0] op, input logic [AW-1:0] a);
    prog[AW'(int'(s) + off)] = {op, a};
  endtask

  task automatic run_prog(input logic [AW-1:0] s, input string tag);
    int n;
    int mism;
    logic [DW-1:0] a0;
    logic [CW-1:0] r0;
    for (int i = 0; i < 256; i++) rdm[i] = dm[i];
    ref_run(s);
    @(negedge clk);
    rst_n = 1'b0;
    start_addr = s;
    @(negedge clk);
    @(negedge clk);
    chk("R1", {tag, " reset pc"}, imem_addr, s);
    chk("R1", {tag, " reset state"}, {acc, zero_flag, carry_flag, halted, retire_cnt, flush_cnt}, 0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    n = 0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R3", {tag, " halt cycle"}, cyc, r_ret + 2 + 2 * r_jmp);
    chk("R4", {tag, " acc"}, acc, r_acc);
    chk("R4", {tag, " flags"}, {zero_flag, carry_flag}, {r_z, r_c});
    chk("R10", {tag, " retired"}, retire_cnt, r_ret);
    chk("R5", {tag, " flushed slots"}, flush_cnt, 2 * r_jmp);
    mism = 0;
    for (int i = 0; i < 16; i++) if (dm[i] !== rdm[i]) mism++;
    chk("R7", {tag, " data memory mismatches"}, mism, 0);
    a0 = acc;
    r0 = retire_cnt;
    repeat (4) @(negedge clk);
    chk("R9", {tag, " frozen after halt"}, {acc, retire_cnt, imem_en, dmem_we}, {a0, r0, 2'b00});
  endtask

  initial begin
    logic [AW-1:0] s;
    int len, r, tg;
    logic [2:0] op;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));

    // Directed 1: wrap-around straight line, untaken JZ, store-to-load reuse.
    clear_prog();
    for (int i = 0; i < 256; i++) dm[i] = '0;
    dm[3] = 16'hFFFF; dm[4] = 16'd2; dm[5] = 16'h1234;
    s = 8'd250;
    put(s, 0, 3'd1, 8'd3);
    put(s, 1, 3'd2, 8'd4);
    put(s, 2, 3'd5, 8'd0);
    put(s, 3, 3'd3, 8'd5);
    put(s, 4, 3'd1, 8'd5);
    put(s, 5, 3'd2, 8'd5);
    put(s, 6, 3'd3, 8'd6);
    put(s, 7, 3'd0, 8'd0);
    put(s, 8, 3'd6, 8'd9);
    put(s, 9, 3'd7, 8'd0);
    run_prog(s, "wrap");
    chk("R2", "first fetch address", tr_addr[0], 250);
    chk("R2", "second fetch address", tr_addr[1], 251);
    chk("R2", "wrapped fetch address", tr_addr[6], 0);
    chk("R3", "nothing retired after two cycles", tr_ret[2], 0);
    chk("R3", "first retire after third cycle", tr_ret[3], 1);
    chk("R3", "one retire per cycle", tr_ret[4], 2);
    chk("R8", "load after store same word", acc, 2);
    chk("R8", "stored sum", dm[6], 2);
    chk("R6", "untaken JZ flushes nothing", flush_cnt, 0);
    chk("R4", "ADD carry then clear", {zero_flag, carry_flag}, 2'b00);

    // Directed 2: JMP then taken JZ, with work placed in discarded slots.
    clear_prog();
    for (int i = 0; i < 256; i++) dm[i] = '0;
    dm[2] = 16'hAAAA; dm[3] = 16'hAAAA; dm[7] = 16'd5;
    s = 8'd16;
    put(s, 0, 3'd1, 8'd1);
    put(s, 1, 3'd4, 8'd21);
    put(s, 2, 3'd3, 8'd2);
    put(s, 3, 3'd2, 8'd7);
    put(s, 4, 3'd7, 8'd0);
    put(s, 5, 3'd5, 8'd24);
    put(s, 6, 3'd3, 8'd3);
    put(s, 7, 3'd7, 8'd0);
    put(s, 8, 3'd2, 8'd7);
    put(s, 9, 3'd3, 8'd9);
    put(s, 10, 3'd7, 8'd0);
    run_prog(s, "jumps");
    chk("R5", "fetch before jump", tr_addr[3], 19);
    chk("R5", "fetch after JMP", tr_addr[4], 21);
    chk("R6", "fetch after taken JZ", tr_addr[7], 24);
    chk("R5", "two jumps flush four", flush_cnt, 4);
    chk("R7", "discarded store 1", dm[2], 16'hAAAA);
    chk("R7", "discarded store 2", dm[3], 16'hAAAA);
    chk("R7", "acc after skipped add", acc, 5);
    chk("R10", "retired excludes discarded", retire_cnt, 6);

    // Directed 3: HALT first.
    clear_prog();
    s = 8'd40;
    run_prog(s, "halt-first");
    chk("R9", "halt-first retires once", retire_cnt, 1);

    // Random forward-jumping programs.
    for (int p = 0; p < 40; p++) begin
      clear_prog();
      for (int i = 0; i < 256; i++) dm[i] = '0;
      for (int i = 0; i < 16; i++) dm[i] = ($urandom % 4 == 0) ? '0 : DW'($urandom);
      len = 6 + int'($urandom % 19);
      s = AW'($urandom);
      for (int i = 0; i < len - 1; i++) begin
        r = int'($urandom % 8);
        a = AW'($urandom % 16);
        case (r)
          0, 1: op = 3'd1;
          2, 3: op = 3'd2;
          4: op = 3'd3;
          5: op = ($urandom % 2 == 0) ? 3'd0 : 3'd6;
          6: op = 3'd4;
          default: op = 3'd5;
        endcase
        if (op == 3'd4 || op == 3'd5) begin
          tg = i + 1 + int'($urandom % 3);
          if (tg > len - 1) tg = len - 1;
          a = AW'(int'(s) + tg);
        end
        put(s, i, op, a);
      end
      put(s, len - 1, 3'd7, 8'd0);
      run_prog(s, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule